// File: doc/BRIEF.md
# Round-Robin Monitor Sequencer with Threshold Flags

This block drives one shared analog-to-digital converter across six monitored quantities: die temperature, supply voltage, two optical power monitors and two bias-current monitors. It requests one conversion at a time and holds the channel select steady while that conversion is in progress. When a result comes back, it scales the result by a programmable right-shift, stores it in that channel's result slot, and compares it against four thresholds: alarm high, alarm low, warning high and warning low. It then updates that channel's four flag bits.

A mask selects which flags may raise a single fault request. At power-up, the low-supply alarm can hold the sequencer in a reduced loop over temperature and supply only. The sequencer leaves that loop for the full rotation once the supply reading is no longer below its low-alarm level.

An input marks the window after a transmit-disable event. During that window, low-side flags on the power and bias channels are kept clear. A one-cycle pulse marks the end of every full rotation, so downstream logic can wait for a complete pass of fresh readings.

Top module: `mon_seq_top`

## Requirements
- R1: Channels are converted in the cyclic order 0 (temperature), 1 (supply), 2 (power 1), 3 (power 2), 4 (bias 1), 5 (bias 2). `conv_start` is a single-cycle pulse and only one conversion is outstanding at a time. `conv_chan` holds its value from the request until the cycle in which `conv_done` is sampled.
- R2: Channels 2 to 5 are right-shifted by 0 to 7 bits. The amount for channel c is taken from `shift_cfg[(c-2)*3 +: 3]`. Channels 0 and 1 are never shifted.
- R3: The shifted value of channel c is written to `results[c*16 +: 16]` on the clock edge that samples `conv_done`. Result slots do not change at any other time.
- R4: For channel c, flag bit c*4+0 is set when the value is strictly above the high alarm, bit c*4+1 when it is strictly below the low alarm, bit c*4+2 when it is strictly above the high warning, and bit c*4+3 when it is strictly below the low warning. The comparison uses the shifted value, and the four bits are rewritten only when channel c completes a conversion.
- R5: `fault_req` is high exactly when some flag bit is set and the `flag_mask` bit at the same position is also set.
- R6: If `flag_mask` bit 5 (supply low alarm) is set, the sequence after reset runs 0,1,0,1,… until a supply result is not below the supply low-alarm threshold. The sequence then continues at channel 2. Once the full rotation is entered, it is kept until the next reset.
- R7: While `txd_ext` is high, a conversion on channels 2 to 5 writes 0 to that channel's low-alarm and low-warning bits, whatever the value.
- R8: `rot_done` pulses high for one cycle, in the cycle after the channel 5 result is written.
- R9: After reset, all result slots and flags are 0, `fault_req` and `rot_done` are 0, `conv_chan` is 0 and `conv_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 3 | Channel being converted |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | 16 | Raw conversion result |
| thr_hi_alm | input | 96 | High alarm thresholds, 16 bits per channel |
| thr_lo_alm | input | 96 | Low alarm thresholds, 16 bits per channel |
| thr_hi_wrn | input | 96 | High warning thresholds, 16 bits per channel |
| thr_lo_wrn | input | 96 | Low warning thresholds, 16 bits per channel |
| shift_cfg | input | 12 | Right-shift amounts for channels 2 to 5 |
| flag_mask | input | 24 | Per-flag enables toward the fault request |
| txd_ext | input | 1 | Extended transmit-disable window active |
| results | output | 96 | Stored shifted results, 16 bits per channel |
| flags | output | 24 | Alarm and warning flags, 4 per channel |
| fault_req | output | 1 | Masked fault request |
| rot_done | output | 1 | Full rotation complete pulse |

## Verification
Two decisions can fall on the same edge. On a power or bias conversion taken during the transmit-disable window, the low-side compare and its suppression coincide. On a supply conversion during power-up, the write of the supply result coincides with the choice between returning to temperature and moving on to channel 2. The bench provokes the first case by feeding zero-valued data with `txd_ext` high and comparing all 24 flags against a model that clears the low bits. It provokes the second case with supply values just below, at and above the low-alarm level, and checks the next `conv_chan` after each one. A sweep of all eight shift amounts against boundary data checks results, flags and fault for each conversion.

// File: rtl/mon_seq_pkg.sv
package mon_seq_pkg;
  localparam int NCH  = 6;
  localparam int NFLG = 4;
  localparam int CHW  = 3;
  localparam int F_HA = 0;
  localparam int F_LA = 1;
  localparam int F_HW = 2;
  localparam int F_LW = 3;

  typedef enum logic [CHW-1:0] {
    CH_TEMP  = 3'd0,
    CH_VSUP  = 3'd1,
    CH_PWR1  = 3'd2,
    CH_PWR2  = 3'd3,
    CH_BIAS1 = 3'd4,
    CH_BIAS2 = 3'd5
  } chan_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mon_rr_ctrl.sv
module mon_rr_ctrl
  import mon_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  conv_done,
  input  logic  guard_req,
  input  logic  vsup_low,
  output logic  conv_start,
  output chan_e chan,
  output logic  wr_en,
  output logic  rot_done
);
  seq_st_e st_q, st_d;
  chan_e   chan_q, chan_d;
  logic    full_q, full_d;
  logic    rot_q, rot_d;

  always_comb begin
    st_d   = st_q;
    chan_d = chan_q;
    full_d = full_q;
    rot_d  = 1'b0;
    wr_en  = 1'b0;
    case (st_q)
      ST_IDLE:  st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done) begin
          wr_en = 1'b1;
          st_d  = ST_ISSUE;
          rot_d = (chan_q == CH_BIAS2);
          if (chan_q == CH_VSUP && !full_q && guard_req && vsup_low) begin
            chan_d = CH_TEMP;
          end else begin
            if (chan_q == CH_VSUP) full_d = 1'b1;
            chan_d = (chan_q == CH_BIAS2) ? CH_TEMP : chan_e'(chan_q + 3'd1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      chan_q <= CH_TEMP;
      full_q <= 1'b0;
      rot_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      chan_q <= chan_d;
      full_q <= full_d;
      rot_q  <= rot_d;
    end
  end

  assign conv_start = (st_q == ST_ISSUE);
  assign chan       = chan_q;
  assign rot_done   = rot_q;
endmodule

// File: rtl/mon_rshift.sv
module mon_rshift #(
  parameter int DW  = 16,
  parameter int SHW = 3
) (
  input  logic [DW-1:0]  din,
  input  logic [SHW-1:0] amt,
  output logic [DW-1:0]  dout
);
  logic [DW-1:0] stg [SHW+1];

  assign stg[0] = din;
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
  end
  assign dout = stg[SHW];
endmodule

// File: rtl/mon_limit_cmp.sv
module mon_limit_cmp
  import mon_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   val,
  input  logic [DW-1:0]   hi_alm,
  input  logic [DW-1:0]   lo_alm,
  input  logic [DW-1:0]   hi_wrn,
  input  logic [DW-1:0]   lo_wrn,
  output logic [NFLG-1:0] hit
);
  always_comb begin
    hit       = '0;
    hit[F_HA] = (val > hi_alm);
    hit[F_LA] = (val < lo_alm);
    hit[F_HW] = (val > hi_wrn);
    hit[F_LW] = (val < lo_wrn);
  end
endmodule

// File: rtl/mon_seq_top.sv
module mon_seq_top
  import mon_seq_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SHW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 conv_start,
  output logic [CHW-1:0]       conv_chan,
  input  logic                 conv_done,
  input  logic [DW-1:0]        conv_data,
  input  logic [NCH*DW-1:0]    thr_hi_alm,
  input  logic [NCH*DW-1:0]    thr_lo_alm,
  input  logic [NCH*DW-1:0]    thr_hi_wrn,
  input  logic [NCH*DW-1:0]    thr_lo_wrn,
  input  logic [(NCH-2)*SHW-1:0] shift_cfg,
  input  logic [NCH*NFLG-1:0]  flag_mask,
  input  logic                 txd_ext,
  output logic [NCH*DW-1:0]    results,
  output logic [NCH*NFLG-1:0]  flags,
  output logic                 fault_req,
  output logic                 rot_done
);
  localparam int NSH    = NCH - 2;
  localparam int GUARDB = int'(CH_VSUP) * NFLG + F_LA;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  chan_e           cur_chan;
  logic            wr_en;
  logic [SHW-1:0]  amt;
  logic [DW-1:0]   shifted;
  logic [DW-1:0]   sel_ha, sel_la, sel_hw, sel_lw;
  logic [NFLG-1:0] hit, hit_q;

  mon_rr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s2),
    .conv_done  (conv_done),
    .guard_req  (flag_mask[GUARDB]),
    .vsup_low   (hit[F_LA]),
    .conv_start (conv_start),
    .chan       (cur_chan),
    .wr_en      (wr_en),
    .rot_done   (rot_done)
  );

  always_comb begin
    amt = '0;
    for (int c = 0; c < NSH; c++) begin
      if (int'(cur_chan) == c + 2) amt = shift_cfg[c*SHW +: SHW];
    end
  end

  always_comb begin
    sel_ha = '0;
    sel_la = '0;
    sel_hw = '0;
    sel_lw = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(cur_chan) == c) begin
        sel_ha = thr_hi_alm[c*DW +: DW];
        sel_la = thr_lo_alm[c*DW +: DW];
        sel_hw = thr_hi_wrn[c*DW +: DW];
        sel_lw = thr_lo_wrn[c*DW +: DW];
      end
    end
  end

  mon_rshift #(.DW(DW), .SHW(SHW)) u_shift (
    .din  (conv_data),
    .amt  (amt),
    .dout (shifted)
  );

  mon_limit_cmp #(.DW(DW)) u_cmp (
    .val    (shifted),
    .hi_alm (sel_ha),
    .lo_alm (sel_la),
    .hi_wrn (sel_hw),
    .lo_wrn (sel_lw),
    .hit    (hit)
  );

  always_comb begin
    hit_q = hit;
    if (txd_ext && cur_chan >= CH_PWR1) begin
      hit_q[F_LA] = 1'b0;
      hit_q[F_LW] = 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic            we;
    logic [DW-1:0]   res_q;
    logic [NFLG-1:0] flg_q;
    assign we = wr_en && (int'(cur_chan) == c);
    always_ff @(posedge clk or negedge rst_s2) begin
      if (!rst_s2) begin
        res_q <= '0;
        flg_q <= '0;
      end else if (we) begin
        res_q <= shifted;
        flg_q <= hit_q;
      end
    end
    assign results[c*DW +: DW]   = res_q;
    assign flags[c*NFLG +: NFLG] = flg_q;
  end

  assign conv_chan = cur_chan;
  assign fault_req = |(flags & flag_mask);
endmodule

// File: rtl/mon_seq_chk.sv
module mon_seq_chk
  import mon_seq_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SHW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_start,
  input logic [CHW-1:0]      conv_chan,
  input logic                conv_done,
  input logic [DW-1:0]       conv_data,
  input logic [NCH*DW-1:0]   thr_lo_alm,
  input logic [NCH*NFLG-1:0] flag_mask,
  input logic                txd_ext,
  input logic [NCH*DW-1:0]   results,
  input logic [NCH*NFLG-1:0] flags,
  input logic                fault_req,
  input logic                rot_done
);
  a_r1_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    conv_chan <= 3'd5);

  a_r1_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r1_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(conv_chan));

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(results));

  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(flags));

  a_r5_no_mask_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_mask == '0) |-> !fault_req);

  a_r6_guard_next: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_start && conv_chan == 3'd1 && flag_mask[NFLG+F_LA]
     && conv_data < thr_lo_alm[DW +: DW]) |=> (conv_chan == 3'd0 || conv_chan == 3'd2));

  a_r8_rot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rot_done |-> (conv_chan == 3'd0 && conv_start));

  a_r8_rot_single: assert property (@(posedge clk) disable iff (!rst_n)
    rot_done |=> !rot_done);

  for (genvar c = 2; c < NCH; c++) begin : g_lo
    a_r7_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_ext && conv_done && !conv_start && conv_chan == 3'(c))
      |=> (flags[c*NFLG+F_LA] == 1'b0 && flags[c*NFLG+F_LW] == 1'b0));
  end
endmodule

bind mon_seq_top mon_seq_chk #(.DW(DW), .SHW(SHW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .thr_lo_alm (thr_lo_alm),
  .flag_mask  (flag_mask),
  .txd_ext    (txd_ext),
  .results    (results),
  .flags      (flags),
  .fault_req  (fault_req),
  .rot_done   (rot_done)
);

// File: tb/mon_seq_top_test.sv
module mon_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done;
  logic [15:0] conv_data;
  logic [95:0] thr_hi_alm, thr_lo_alm, thr_hi_wrn, thr_lo_wrn;
  logic [11:0] shift_cfg;
  logic [23:0] flag_mask;
  logic        txd_ext;
  logic [95:0] results;
  logic [23:0] flags;
  logic        fault_req;
  logic        rot_done;

  int nchk = 0;
  int nfail = 0;
  int exp_res [6];
  logic [3:0] exp_flg [6];
  int exp_chan;
  bit full;

  always #2.5 clk = ~clk;

  mon_seq_top uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data),
    .thr_hi_alm(thr_hi_alm), .thr_lo_alm(thr_lo_alm),
    .thr_hi_wrn(thr_hi_wrn), .thr_lo_wrn(thr_lo_wrn),
    .shift_cfg(shift_cfg), .flag_mask(flag_mask), .txd_ext(txd_ext),
    .results(results), .flags(flags), .fault_req(fault_req), .rot_done(rot_done)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    conv_done = 1'b0;
    conv_data = '0;
    for (int c = 0; c < 6; c++) begin
      exp_res[c] = 0;
      exp_flg[c] = '0;
    end
    exp_chan = 0;
    full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 conv_chan", 96'(conv_chan), 96'(0));
    chk("R9 conv_start", 96'(conv_start), 96'(0));
    chk("R9 results", results, 96'(0));
    chk("R9 flags", 96'(flags), 96'(0));
    chk("R9 fault/rot", 96'({fault_req, rot_done}), 96'(0));
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0FFF;
      2: return 16'h1000;
      3: return 16'h1FFF;
      4: return 16'hA000;
      5: return 16'hA001;
      6: return 16'hC100;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic do_conv(input logic [15:0] d);
    int got, sh;
    logic [15:0] v;
    logic [3:0] fl;
    logic [95:0] er;
    logic [23:0] ef;
    while (conv_start !== 1'b1) @(negedge clk);
    got = int'(conv_chan);
    chk("R1 channel order", 96'(got), 96'(exp_chan));
    @(negedge clk);
    chk("R1 start single pulse", 96'(conv_start), 96'(0));
    @(negedge clk);
    conv_data = d;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    sh = (got >= 2) ? int'(shift_cfg[(got-2)*3 +: 3]) : 0;
    v = d >> sh;
    fl[0] = v > thr_hi_alm[got*16 +: 16];
    fl[1] = v < thr_lo_alm[got*16 +: 16];
    fl[2] = v > thr_hi_wrn[got*16 +: 16];
    fl[3] = v < thr_lo_wrn[got*16 +: 16];
    if (txd_ext && got >= 2) begin
      fl[1] = 1'b0;
      fl[3] = 1'b0;
    end
    exp_res[got] = int'(v);
    exp_flg[got] = fl;
    if (got == 1 && !full && flag_mask[5] && v < thr_lo_alm[16 +: 16]) begin
      exp_chan = 0;
    end else begin
      if (got == 1) full = 1'b1;
      exp_chan = (got == 5) ? 0 : got + 1;
    end
    for (int c = 0; c < 6; c++) begin
      er[c*16 +: 16] = exp_res[c][15:0];
      ef[c*4 +: 4] = exp_flg[c];
    end
    chk("R2 R3 results", results, er);
    chk("R4 R7 flags", 96'(flags), 96'(ef));
    chk("R5 fault_req", 96'(fault_req), 96'(|(ef & flag_mask)));
    chk("R8 rot_done", 96'(rot_done), 96'(got == 5));
    chk("R1 R6 next channel", 96'(conv_chan), 96'(exp_chan));
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) begin
      thr_hi_alm[c*16 +: 16] = 16'hC000 + 16'(c * 256);
      thr_lo_alm[c*16 +: 16] = 16'h1000 + 16'(c * 16);
      thr_hi_wrn[c*16 +: 16] = 16'hA000;
      thr_lo_wrn[c*16 +: 16] = 16'h2000;
    end
    txd_ext = 1'b0;
    shift_cfg = '0;
    flag_mask = 24'h0;
    do_reset();

    // R2 R4 R5: all shift amounts against boundary data, varying masks
    for (int s = 0; s < 8; s++) begin
      shift_cfg = {3'(7 - s), 3'((s + 3) % 8), 3'((s + 1) % 8), 3'(s)};
      for (int i = 0; i < 8; i++) begin
        flag_mask = (24'h5A5A5A ^ 24'(s * 24'h0111 + i * 24'h1003)) & ~24'h20;
        for (int c = 0; c < 6; c++) do_conv(pick((i + c) % 8));
      end
    end

    // R7: low values during transmit-disable window, then outside it
    shift_cfg = '0;
    flag_mask = 24'hFFFFDF;
    txd_ext = 1'b1;
    for (int c = 0; c < 6; c++) do_conv(16'h0000);
    txd_ext = 1'b0;
    for (int c = 0; c < 6; c++) do_conv(16'h0005);
    txd_ext = 1'b1;
    for (int c = 0; c < 6; c++) do_conv(16'hFFFF);
    txd_ext = 1'b0;

    // R6: power-up guard loop with supply below, at and above low alarm
    flag_mask = 24'hFFFFFF;
    do_reset();
    do_conv(16'h5000); do_conv(16'h0800);
    do_conv(16'h5000); do_conv(16'h100F);
    do_conv(16'h5000); do_conv(16'h1010);
    for (int c = 2; c < 6; c++) do_conv(16'h4000);
    do_conv(16'h5000); do_conv(16'h0000);
    for (int c = 2; c < 6; c++) do_conv(16'h4000);

    // R6: guard enabled but supply already good
    do_reset();
    for (int c = 0; c < 6; c++) do_conv(16'h3000);

    // R6: guard disabled, low supply does not hold the loop
    flag_mask = 24'hFFFFDF;
    do_reset();
    for (int c = 0; c < 6; c++) do_conv(16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule